// File: doc/BRIEF.md
# Ingress Packet Parser and Buffer

This block is the receive half of one switch port. Bytes arrive already deserialized, one per cycle when `in_valid` is high, and packets follow one another back to back with no framing signal. The block counts bytes against the packet length set by the network-wide size configuration. It decodes the leading header bytes and keeps a running CRC-8. If the packet passes every check, it holds the whole packet in a local one-packet store.

A stored packet is offered to the central router one byte per transfer. Each byte carries the index of the output port it must leave on, so the router needs no header parsing and no storage of its own. A packet is discarded, and counted, in four cases: its size code disagrees with the configuration, its destination port is not connected, its CRC fails, or the store is still occupied when its first byte arrives. There is no back-pressure toward the sender.

Top module: `ingress_port`

## Requirements
- R1: While reset is active and in the first cycle after it, `out_valid` is 0 and `drop_count` is 0.
- R2: Header layout:
  - Byte 0 carries the size code in bits [7:6] and a command in bits [5:0].
  - Byte 1 is the destination address. Its low two bits select the output port.
  - Byte 2 is the source address.
  - Size codes 0, 1, 2 and 3 give total packet lengths of 128, 256, 512 and 1024 bytes. The length counts header, payload and CRC bytes.
- R3: An accepted packet is offered from the cycle after its last byte arrives. All of its bytes, CRC included, appear in arrival order, each with `out_dest` equal to byte 1 bits [1:0].
- R4: A byte is consumed only in a cycle where `out_valid` and `out_read` are both 1. Otherwise `out_byte` and `out_dest` hold. `out_valid` falls only after the final byte is read.
- R5: The last byte is a CRC-8 over every earlier byte of the packet, using polynomial 0x07, initial value 0x00, most significant bit first and no final inversion. A mismatch discards the packet.
- R6: A packet whose byte 0 bits [7:6] differ from `cfg_size` is discarded. It still spans the configured length.
- R7: A packet whose destination port has its `cfg_port_en` bit at 0 is discarded.
- R8: A packet whose first byte arrives while the store holds unread bytes (other than a final byte read in that same cycle) is discarded. The stored packet is delivered unchanged.
- R9: If the final stored byte is read in the same cycle that a new packet's first byte arrives, the new packet is accepted.
- R10: `drop_count` rises by exactly one for each discarded packet, in the cycle after that packet's last byte.
- R11: The command bits [5:0] of byte 0 have no effect on acceptance, routing or delivered data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_byte | input | 8 | Received byte |
| in_valid | input | 1 | `in_byte` holds a packet byte this cycle |
| cfg_size | input | 2 | Agreed network packet-size code |
| cfg_port_en | input | 4 | One bit per output port: port is connected |
| out_byte | output | 8 | Stored byte offered to the router |
| out_dest | output | 2 | Output port for `out_byte` |
| out_valid | output | 1 | A stored byte is on offer |
| out_read | input | 1 | Router takes the offered byte this cycle |
| drop_count | output | 16 | Number of discarded packets, wrapping |

## Verification
The two functions that meet in one cycle are the router reading the final stored byte and the arrival of the first byte of the next packet. That cycle decides whether the store counts as free. The bench holds reads off until a packet is stored, then enables reads at a known cycle. It counts off exactly enough cycles that the next packet's first byte lands on the final read, and then one cycle earlier. The first case must deliver the new packet with no added drop. The second must drop it while the old packet drains intact.

// File: rtl/ingress_pkg.sv
package ingress_pkg;

    localparam int SIZE_W = 2;
    localparam logic [7:0] CRC_POLY = 8'h07;

    // One byte of CRC-8 update, MSB first, no reflection.
    function automatic logic [7:0] crc8_next(input logic [7:0] crc, input logic [7:0] data);
        logic [7:0] c;
        c = crc ^ data;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ({c[6:0], 1'b0} ^ CRC_POLY) : {c[6:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/ingress_rx_ctl.sv
module ingress_rx_ctl
    import ingress_pkg::*;
#(
    parameter int BASE_LEN = 128,
    parameter int NPORTS   = 4,
    parameter int CNT_W    = 16,
    localparam int MAX_LEN = BASE_LEN * 8,
    localparam int IDX_W   = $clog2(MAX_LEN),
    localparam int PORT_W  = $clog2(NPORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        in_byte,
    input  logic              in_valid,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic [NPORTS-1:0] cfg_port_en,
    input  logic              buf_free,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_addr,
    output logic [7:0]        wr_data,
    output logic              commit,
    output logic [IDX_W-1:0]  commit_last,
    output logic [PORT_W-1:0] commit_dest,
    output logic              drop_pulse,
    output logic [CNT_W-1:0]  drop_count
);

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last;
        logic              keep;
        logic [7:0]        crc;
        logic [PORT_W-1:0] dest;
        logic [CNT_W-1:0]  drops;
    } rx_t;

    rx_t r_d, r_q;
    logic [IDX_W:0]   len_sel;
    logic [IDX_W-1:0] last_sel;

    always_comb begin
        len_sel  = (IDX_W + 1)'(BASE_LEN) << cfg_size;
        last_sel = len_sel[IDX_W-1:0] - 1'b1;
    end

    always_comb begin
        r_d         = r_q;
        commit      = 1'b0;
        drop_pulse  = 1'b0;
        wr_addr     = r_q.idx;
        wr_data     = in_byte;
        commit_last = r_q.last;
        commit_dest = r_q.dest;
        if (in_valid) begin
            if (r_q.idx == '0) begin
                r_d.last = last_sel;
                r_d.keep = buf_free && (in_byte[7:6] == cfg_size);
                r_d.crc  = crc8_next(8'h00, in_byte);
                r_d.idx  = IDX_W'(1);
            end else if (r_q.idx == r_q.last) begin
                if (r_q.keep && (in_byte == r_q.crc)) begin
                    commit = 1'b1;
                end else begin
                    drop_pulse = 1'b1;
                    r_d.drops  = r_q.drops + 1'b1;
                end
                r_d.idx = '0;
            end else begin
                r_d.crc = crc8_next(r_q.crc, in_byte);
                r_d.idx = r_q.idx + 1'b1;
                if (r_q.idx == IDX_W'(1)) begin
                    r_d.dest = in_byte[PORT_W-1:0];
                    r_d.keep = r_q.keep && cfg_port_en[in_byte[PORT_W-1:0]];
                end
            end
        end
        wr_en = in_valid && r_d.keep;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign drop_count = r_q.drops;

endmodule

// File: rtl/ingress_pkt_buf.sv
module ingress_pkt_buf #(
    parameter int BASE_LEN = 128,
    parameter int NPORTS   = 4,
    localparam int MAX_LEN = BASE_LEN * 8,
    localparam int IDX_W   = $clog2(MAX_LEN),
    localparam int PORT_W  = $clog2(NPORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              commit,
    input  logic [IDX_W-1:0]  commit_last,
    input  logic [PORT_W-1:0] commit_dest,
    input  logic              out_read,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    output logic [PORT_W-1:0] out_dest,
    output logic              buf_free
);

    typedef struct packed {
        logic              full;
        logic [IDX_W-1:0]  rd;
        logic [IDX_W-1:0]  last;
        logic [PORT_W-1:0] dest;
    } buf_t;

    buf_t b_d, b_q;
    logic [7:0] store [MAX_LEN];
    logic       fire;
    logic       final_read;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        fire       = b_q.full && out_read;
        final_read = fire && (b_q.rd == b_q.last);
        buf_free   = !b_q.full || final_read;
        b_d        = b_q;
        if (fire) begin
            if (final_read) begin
                b_d.full = 1'b0;
                b_d.rd   = '0;
            end else begin
                b_d.rd = b_q.rd + 1'b1;
            end
        end
        if (commit) begin
            b_d.full = 1'b1;
            b_d.rd   = '0;
            b_d.last = commit_last;
            b_d.dest = commit_dest;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign out_valid = b_q.full;
    assign out_byte  = store[b_q.rd];
    assign out_dest  = b_q.dest;

endmodule

// File: rtl/ingress_port.sv
module ingress_port
    import ingress_pkg::*;
#(
    parameter int BASE_LEN = 128,
    parameter int NPORTS   = 4,
    parameter int CNT_W    = 16,
    localparam int MAX_LEN = BASE_LEN * 8,
    localparam int IDX_W   = $clog2(MAX_LEN),
    localparam int PORT_W  = $clog2(NPORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        in_byte,
    input  logic              in_valid,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic [NPORTS-1:0] cfg_port_en,
    output logic [7:0]        out_byte,
    output logic [PORT_W-1:0] out_dest,
    output logic              out_valid,
    input  logic              out_read,
    output logic [CNT_W-1:0]  drop_count
);

    logic              wr_en;
    logic [IDX_W-1:0]  wr_addr;
    logic [7:0]        wr_data;
    logic              commit;
    logic [IDX_W-1:0]  commit_last;
    logic [PORT_W-1:0] commit_dest;
    logic              drop_pulse;
    logic              buf_free;

    ingress_rx_ctl #(
        .BASE_LEN (BASE_LEN),
        .NPORTS   (NPORTS),
        .CNT_W    (CNT_W)
    ) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_byte     (in_byte),
        .in_valid    (in_valid),
        .cfg_size    (cfg_size),
        .cfg_port_en (cfg_port_en),
        .buf_free    (buf_free),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .commit      (commit),
        .commit_last (commit_last),
        .commit_dest (commit_dest),
        .drop_pulse  (drop_pulse),
        .drop_count  (drop_count)
    );

    ingress_pkt_buf #(
        .BASE_LEN (BASE_LEN),
        .NPORTS   (NPORTS)
    ) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .commit      (commit),
        .commit_last (commit_last),
        .commit_dest (commit_dest),
        .out_read    (out_read),
        .out_valid   (out_valid),
        .out_byte    (out_byte),
        .out_dest    (out_dest),
        .buf_free    (buf_free)
    );

endmodule

// File: rtl/ingress_port_chk.sv
module ingress_port_chk #(
    parameter int CNT_W  = 16,
    parameter int PORT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              out_read,
    input logic [7:0]        out_byte,
    input logic [PORT_W-1:0] out_dest,
    input logic [CNT_W-1:0]  drop_count,
    input logic              commit,
    input logic              drop_pulse
);

    // R4: an offered byte not taken stays on the bus unchanged
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_read) |=> (out_valid && $stable(out_byte) && $stable(out_dest)));

    // R4: the offer ends only through a read
    assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> $past(out_read));

    // R3: a packet that passes its checks is offered next cycle
    assert_offer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> out_valid);

    // R8: a completed packet never lands on an occupied store
    assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !out_valid);

    // R10: the counter moves by one per discard and otherwise holds
    assert_drop_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (drop_count == $past(drop_count) + CNT_W'($past(drop_pulse))));

endmodule

bind ingress_port ingress_port_chk #(
    .CNT_W  (CNT_W),
    .PORT_W (PORT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_valid  (out_valid),
    .out_read   (out_read),
    .out_byte   (out_byte),
    .out_dest   (out_dest),
    .drop_count (drop_count),
    .commit     (commit),
    .drop_pulse (drop_pulse)
);

// File: tb/sim_ingress_port.sv
`timescale 1ns/1ps
module sim_ingress_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_valid = 1'b0;
    logic [1:0] cfg_size = 2'd0;
    logic [3:0] cfg_port_en = 4'hF;
    logic [7:0] out_byte;
    logic [1:0] out_dest;
    logic       out_valid;
    logic       out_read = 1'b0;
    logic [15:0] drop_count;

    int errors = 0;
    int checks = 0;
    int rd_mode = 0;
    int exp_drops = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit started = 1'b0;

    always #2.5 clk = ~clk;

    ingress_port u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_byte     (in_byte),
        .in_valid    (in_valid),
        .cfg_size    (cfg_size),
        .cfg_port_en (cfg_port_en),
        .out_byte    (out_byte),
        .out_dest    (out_dest),
        .out_valid   (out_valid),
        .out_read    (out_read),
        .drop_count  (drop_count)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c;
        for (int k = 7; k >= 0; k--) begin
            if (r[7] ^ d[k]) r = (r << 1) ^ 8'h07;
            else             r = r << 1;
        end
        return r;
    endfunction

    // Behavioural reference model, updated at each rising edge
    logic [7:0] ref_q[$];
    logic [7:0] rx_q[$];
    logic [1:0] ref_dest;
    int  ref_drops;
    int  rx_len;
    bit  rx_ok;
    always @(posedge clk) begin : model
        bit was_free;
        logic [7:0] c;
        if (!rst_n) begin
            ref_q.delete();
            rx_q.delete();
            ref_drops = 0;
            ref_dest  = 2'd0;
        end else begin
            was_free = (ref_q.size() == 0) || (out_read && ref_q.size() == 1);
            if (out_read && ref_q.size() > 0) void'(ref_q.pop_front());
            if (in_valid) begin
                if (rx_q.size() == 0) begin
                    rx_len = 128 << cfg_size;
                    rx_ok  = was_free && (in_byte[7:6] == cfg_size);
                end
                rx_q.push_back(in_byte);
                if (rx_q.size() == 2 && !cfg_port_en[in_byte[1:0]]) rx_ok = 1'b0;
                if (rx_q.size() == rx_len) begin
                    c = 8'h00;
                    for (int k = 0; k < rx_len - 1; k++) c = ref_crc(c, rx_q[k]);
                    if (rx_ok && c == rx_q[rx_len-1]) begin
                        ref_q    = rx_q;
                        ref_dest = rx_q[1][1:0];
                    end else begin
                        ref_drops++;
                    end
                    rx_q.delete();
                end
            end
        end
    end

    // Compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && started) begin
            chk("R3 out_valid", int'(out_valid), int'(ref_q.size() > 0));
            if (ref_q.size() > 0) begin
                chk("R3 out_byte", int'(out_byte), int'(ref_q[0]));
                chk("R2 out_dest", int'(out_dest), int'(ref_dest));
            end
            chk("R10 drop_count", int'(drop_count), ref_drops);
        end
    end

    task automatic tick();
        if (rd_mode == 2) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_read = lfsr[0];
        end else begin
            out_read = (rd_mode == 1);
        end
        @(negedge clk);
    endtask

    task automatic send_pkt(input logic [1:0] code, input int len, input logic [5:0] cmd,
                            input logic [7:0] dst, input logic [7:0] seed,
                            input bit bad_crc, input bit gaps);
        logic [7:0] pk[];
        logic [7:0] c;
        pk = new[len];
        pk[0] = {code, cmd};
        pk[1] = dst;
        pk[2] = 8'hA5 ^ seed;
        for (int i = 3; i < len - 1; i++) pk[i] = seed + 8'(i * 7);
        c = 8'h00;
        for (int i = 0; i < len - 1; i++) c = ref_crc(c, pk[i]);
        pk[len-1] = bad_crc ? (c ^ 8'h01) : c;
        for (int i = 0; i < len; i++) begin
            in_byte  = pk[i];
            in_valid = 1'b1;
            tick();
            if (gaps && (i % 5 == 2)) begin
                in_valid = 1'b0;
                tick();
            end
        end
        in_valid = 1'b0;
    endtask

    task automatic drain();
        rd_mode = 1;
        while (ref_q.size() != 0 || out_valid) tick();
        tick();
    endtask

    initial begin : watchdog
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        chk("R1 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after reset", int'(out_valid), 0);
        chk("R1 drop_count after reset", int'(drop_count), 0);
        started = 1'b1;

        // R3: plain packet, router always reading
        rd_mode = 1;
        send_pkt(2'd0, 128, 6'h01, 8'h01, 8'h10, 1'b0, 1'b0);
        chk("R3 offered after last byte", int'(out_valid), 1);
        chk("R2 dest from byte 1", int'(out_dest), 1);
        drain();

        // R4: gaps on input, random reads
        rd_mode = 2;
        send_pkt(2'd0, 128, 6'h02, 8'h02, 8'h33, 1'b0, 1'b1);
        repeat (40) tick();
        drain();

        // R5: corrupted CRC
        send_pkt(2'd0, 128, 6'h03, 8'h03, 8'h44, 1'b1, 1'b0);
        exp_drops++;
        tick();
        chk("R5 bad CRC not offered", int'(out_valid), 0);
        chk("R5 bad CRC counted", int'(drop_count), exp_drops);

        // R6: larger agreed size, then a mismatching code
        cfg_size = 2'd1;
        send_pkt(2'd1, 256, 6'h04, 8'h00, 8'h55, 1'b0, 1'b0);
        chk("R2 256-byte packet accepted", int'(out_valid), 1);
        drain();
        send_pkt(2'd0, 256, 6'h05, 8'h00, 8'h66, 1'b0, 1'b0);
        exp_drops++;
        tick();
        chk("R6 size mismatch counted", int'(drop_count), exp_drops);
        chk("R6 size mismatch not offered", int'(out_valid), 0);
        cfg_size = 2'd0;

        // R7: disconnected port
        cfg_port_en = 4'b1011;
        send_pkt(2'd0, 128, 6'h06, 8'h06, 8'h77, 1'b0, 1'b0);
        exp_drops++;
        tick();
        chk("R7 disconnected port counted", int'(drop_count), exp_drops);
        send_pkt(2'd0, 128, 6'h07, 8'h87, 8'h78, 1'b0, 1'b0);
        chk("R7 connected port 3 accepted", int'(out_valid), 1);
        chk("R2 low bits of address give port", int'(out_dest), 3);
        drain();
        cfg_port_en = 4'hF;

        // R11: command bits vary, routing unchanged
        send_pkt(2'd0, 128, 6'h3F, 8'h02, 8'h21, 1'b0, 1'b0);
        chk("R11 command ignored", int'(out_dest), 2);
        drain();

        // R8: second packet while store occupied
        rd_mode = 0;
        send_pkt(2'd0, 128, 6'h08, 8'h01, 8'h90, 1'b0, 1'b0);
        send_pkt(2'd0, 128, 6'h09, 8'h02, 8'h91, 1'b0, 1'b0);
        exp_drops++;
        tick();
        chk("R8 busy drop counted", int'(drop_count), exp_drops);
        chk("R8 stored packet kept dest", int'(out_dest), 1);
        drain();

        // R9: final read coincides with next first byte
        rd_mode = 0;
        send_pkt(2'd0, 128, 6'h0A, 8'h01, 8'hA0, 1'b0, 1'b0);
        rd_mode = 1;
        repeat (127) tick();
        send_pkt(2'd0, 128, 6'h0B, 8'h03, 8'hA1, 1'b0, 1'b0);
        rd_mode = 0;
        tick();
        chk("R9 same-cycle free accepted", int'(out_valid), 1);
        chk("R9 accepted packet dest", int'(out_dest), 3);
        chk("R9 no drop", int'(drop_count), exp_drops);
        drain();

        // R8: one cycle early, two bytes still unread
        rd_mode = 0;
        send_pkt(2'd0, 128, 6'h0C, 8'h01, 8'hB0, 1'b0, 1'b0);
        rd_mode = 1;
        repeat (126) tick();
        send_pkt(2'd0, 128, 6'h0D, 8'h02, 8'hB1, 1'b0, 1'b0);
        exp_drops++;
        tick();
        chk("R8 one-early drop counted", int'(drop_count), exp_drops);
        chk("R8 one-early nothing offered", int'(out_valid), 0);
        drain();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule